// File: doc/BRIEF.md
# Prescaled Interval Timer with Fractional Period Correction

This block is a 32-bit up-counter for use as a system tick or a free-running time base. A small single-cycle register port controls it. Its input clock can pass through a power-of-two prescaler. When the counter wraps past its all-ones value it either reloads from a programmable value and keeps running, or stops. Each wrap raises an overflow flag. Software clears that flag by writing a one to it, and an enable bit gates the flag onto a registered interrupt line. The live count is also available on a port.

A correction mode gives an average wrap period that is not a whole number of ticks. This is useful when a coarse reference clock must produce a precise tick rate. A signed accumulator is updated at every wrap, adding either a programmed positive increment or a programmed negative increment. When the accumulator is negative at a wrap, the next period is made one tick longer. Over a complete accumulator cycle, the average period comes out exact.

Register port: a write takes effect on the clock edge where `reg_wr` is high. `reg_rdata` is registered, and one cycle after `reg_addr` is presented it shows the register at that address. Word addresses: 0 control, 1 counter, 2 reload value, 3 status, 4 interrupt enable, 5 positive increment, 6 negative increment.

Top module: `tick_timer`

## Requirements
- R1: After synchronous reset, `count_o` is 0, `irq_o` is 0, and the control, reload, status, enable and increment registers read 0. The correction accumulator is also 0.
- R2: Control bit 0 (run) enables counting. While it is 0, `count_o` holds its value. Clearing it freezes the count, and that count is then held indefinitely.
- R3: With control bit 2 (prescale enable) at 0, the count advances once per clock while running. With it at 1, the count advances once every 2^(S+1) clocks, where S is control bits [5:3]. Counting is measured from the edge that sets run.
- R4: With control bit 1 (auto-reload) at 1, the tick that carries the count past 0xFFFFFFFF loads the count from the reload register (address 2) and sets status bit 1 (overflow).
- R5: With auto-reload at 0, a wrap leaves the count at 0, sets status bit 1 and clears the run bit.
- R6: Writing status (address 3) clears each flag whose data bit is 1 and leaves every flag whose data bit is 0 unchanged. Bit 1 is overflow. Bits 0 (match) and 2 (capture) exist but have no set source, so they read 0.
- R7: If an overflow occurs on the same edge as a write that clears the overflow flag, the flag ends up set.
- R8: `irq_o` is 1 exactly when the overflow flag and interrupt-enable bit 1 (address 4) are both 1.
- R9: Correction is active when either increment register (addresses 5 and 6) is non-zero. At each wrap, if the accumulator is non-negative, the negative increment is added and the next period has normal length. If the accumulator is negative, the positive increment is added and the count reloads with the reload value minus 1, so the next period is one tick longer.
- R10: With both increments at 0, every period has its plain length and the count always reloads with exactly the reload value.
- R11: With reload value 0xFFFFFFE0, positive increment 232000 and negative increment -768000, starting from a reset accumulator, the 1000 periods following the first wrap total exactly 32768 ticks, and 768 of them are stretched.
- R12: A write to the counter (address 1) sets `count_o` to the written value on the same edge and restarts the prescale phase. A write to the reload register takes effect on the same edge and reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's address |
| irq_o | output | 1 | Overflow interrupt request |
| count_o | output | 32 | Current counter value |

## Verification
The bench uses the default 32-bit counter and the default 3-bit prescale field, so all eight divide ratios from 2 to 256 are reachable. Random start offsets and divide ratios are checked against the clock count to overflow that the bench computes. Because the counter is a full 32 bits, wraps are reached by loading values just below all-ones rather than by counting from zero. The 0xFFFFFFE0 reload gives a 32-tick base period. With a divide-by-2 prescaler, the complete 125-wrap accumulator cycle repeats eight times within about 66,000 clocks, so the exact-average claim is checked over a full 1000 wraps.

// File: rtl/tt_pkg.sv
package tt_pkg;

  localparam int ADDR_W = 3;
  localparam int FLAG_N = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL  = 3'd0,
    RA_COUNT = 3'd1,
    RA_LOAD  = 3'd2,
    RA_STAT  = 3'd3,
    RA_IEN   = 3'd4,
    RA_PINC  = 3'd5,
    RA_NINC  = 3'd6
  } reg_addr_e;

  // flag bit positions in status and enable registers
  localparam int FL_MATCH = 0;
  localparam int FL_OVF   = 1;
  localparam int FL_CAPT  = 2;

  typedef struct packed {
    logic       ovf_trig;
    logic [2:0] pre_sel;
    logic       pre_en;
    logic       reload;
    logic       run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
  parameter int PSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              enable,
  input  logic [PSEL_W-1:0] sel,
  input  logic              restart,
  output logic              tick
);
  localparam int PC_W = 1 << PSEL_W;

  logic [PC_W-1:0]   phase_q;
  logic [PSEL_W:0]   shift_amt;
  logic [PC_W:0]     span;
  logic [PC_W-1:0]   limit;

  always_comb begin
    shift_amt = {1'b0, sel} + {{PSEL_W{1'b0}}, 1'b1};
    span      = {{PC_W{1'b0}}, 1'b1} << shift_amt;
    limit     = enable ? (span[PC_W-1:0] - {{(PC_W-1){1'b0}}, 1'b1})
                       : {PC_W{1'b0}};
    tick      = run && (phase_q == limit);
  end

  always_ff @(posedge clk) begin
    if (rst || !run || restart || tick) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + {{(PC_W-1){1'b0}}, 1'b1};
    end
  end
endmodule

// File: rtl/tt_corrector.sv
module tt_corrector #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wrap,
  input  logic [W-1:0] pos_inc,
  input  logic [W-1:0] neg_inc,
  output logic         stretch
);
  logic [W-1:0] acc_q;
  logic         active;

  always_comb begin
    active  = (|pos_inc) || (|neg_inc);
    stretch = active && acc_q[W-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else if (wrap && active) begin
      acc_q <= acc_q + (acc_q[W-1] ? pos_inc : neg_inc);
    end
  end
endmodule

// File: rtl/tt_counter.sv
module tt_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  input  logic         reload_en,
  input  logic [W-1:0] load_val,
  input  logic         stretch,
  output logic [W-1:0] count,
  output logic         wrap
);
  logic [W-1:0] count_q;
  logic [W-1:0] restart_val;

  always_comb begin
    wrap        = tick && (&count_q) && !wr_en;
    restart_val = load_val - {{(W-1){1'b0}}, stretch};
    count       = count_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (wr_en) begin
      count_q <= wr_val;
    end else if (wrap) begin
      count_q <= reload_en ? restart_val : '0;
    end else if (tick) begin
      count_q <= count_q + {{(W-1){1'b0}}, 1'b1};
    end
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic              irq_o,
  output logic [CNT_W-1:0]  count_o
);
  ctrl_t             ctrl_q;
  logic [CNT_W-1:0]  load_q;
  logic [CNT_W-1:0]  pinc_q;
  logic [CNT_W-1:0]  ninc_q;
  logic [FLAG_N-1:0] stat_q;
  logic [FLAG_N-1:0] ien_q;
  logic [FLAG_N-1:0] stat_nxt;
  logic [FLAG_N-1:0] ien_nxt;
  logic [FLAG_N-1:0] flag_set;
  logic [FLAG_N-1:0] flag_clr;
  logic [CNT_W-1:0]  rdata_q;
  logic              irq_q;

  logic wr_ctrl, wr_count, wr_load, wr_stat, wr_ien, wr_pinc, wr_ninc;
  logic tick, wrap, stretch;
  logic [CNT_W-1:0] count_w;

  always_comb begin
    wr_ctrl  = reg_wr && (reg_addr == RA_CTRL);
    wr_count = reg_wr && (reg_addr == RA_COUNT);
    wr_load  = reg_wr && (reg_addr == RA_LOAD);
    wr_stat  = reg_wr && (reg_addr == RA_STAT);
    wr_ien   = reg_wr && (reg_addr == RA_IEN);
    wr_pinc  = reg_wr && (reg_addr == RA_PINC);
    wr_ninc  = reg_wr && (reg_addr == RA_NINC);
  end

  tt_prescaler #(.PSEL_W(PSEL_W)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .run     (ctrl_q.run),
    .enable  (ctrl_q.pre_en),
    .sel     (ctrl_q.pre_sel),
    .restart (wr_count),
    .tick    (tick)
  );

  tt_counter #(.W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .wr_en     (wr_count),
    .wr_val    (reg_wdata),
    .reload_en (ctrl_q.reload),
    .load_val  (load_q),
    .stretch   (stretch),
    .count     (count_w),
    .wrap      (wrap)
  );

  tt_corrector #(.W(CNT_W)) u_cor (
    .clk     (clk),
    .rst     (rst),
    .wrap    (wrap),
    .pos_inc (pinc_q),
    .neg_inc (ninc_q),
    .stretch (stretch)
  );

  // flag update: a new event outranks a same-cycle clear
  always_comb begin
    flag_set         = '0;
    flag_set[FL_OVF] = wrap;
    flag_clr         = wr_stat ? reg_wdata[FLAG_N-1:0] : '0;
    stat_nxt         = (stat_q & ~flag_clr) | flag_set;
    ien_nxt          = wr_ien ? reg_wdata[FLAG_N-1:0] : ien_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      load_q <= '0;
      pinc_q <= '0;
      ninc_q <= '0;
      stat_q <= '0;
      ien_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
      end else if (wrap && !ctrl_q.reload) begin
        ctrl_q.run <= 1'b0;
      end
      if (wr_load) load_q <= reg_wdata;
      if (wr_pinc) pinc_q <= reg_wdata;
      if (wr_ninc) ninc_q <= reg_wdata;
      stat_q <= stat_nxt;
      ien_q  <= ien_nxt;
      irq_q  <= |(stat_nxt & ien_nxt);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      case (reg_addr)
        RA_CTRL:  rdata_q <= {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
        RA_COUNT: rdata_q <= count_w;
        RA_LOAD:  rdata_q <= load_q;
        RA_STAT:  rdata_q <= {{(CNT_W-FLAG_N){1'b0}}, stat_q};
        RA_IEN:   rdata_q <= {{(CNT_W-FLAG_N){1'b0}}, ien_q};
        RA_PINC:  rdata_q <= pinc_q;
        RA_NINC:  rdata_q <= ninc_q;
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign reg_rdata = rdata_q;
  assign irq_o     = irq_q;
  assign count_o   = count_w;
endmodule

// File: rtl/tt_checker.sv
module tt_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         reg_wr,
  input logic [2:0]   reg_addr,
  input logic [W-1:0] reg_wdata,
  input logic         run,
  input logic         reload,
  input logic         wrap,
  input logic         ovf_flag,
  input logic         ovf_en,
  input logic         irq_o,
  input logic [W-1:0] count_o,
  input logic [W-1:0] load
);
  logic cwr, ctl_wr, st_wr;
  assign cwr    = reg_wr && (reg_addr == 3'd1);
  assign ctl_wr = reg_wr && (reg_addr == 3'd0);
  assign st_wr  = reg_wr && (reg_addr == 3'd3);

  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (rst) irq_o == (ovf_flag && ovf_en)); // R8
  AST_FROZEN: assert property (@(posedge clk) disable iff (rst) (!run && !cwr) |=> count_o == $past(count_o)); // R2
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst) (run && !cwr && !wrap) |=> (count_o == $past(count_o) || count_o == $past(count_o) + 1'b1)); // R3
  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (rst) wrap |=> ovf_flag); // R7
  AST_RELOAD_VAL: assert property (@(posedge clk) disable iff (rst) (wrap && reload) |=> (count_o == $past(load) || count_o == $past(load) - 1'b1)); // R4
  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (rst) (wrap && !reload && !ctl_wr) |=> (!run && count_o == '0)); // R5
  AST_W1C: assert property (@(posedge clk) disable iff (rst) (st_wr && reg_wdata[1] && !wrap) |=> !ovf_flag); // R6
endmodule

bind tick_timer tt_checker #(.W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .run       (ctrl_q.run),
  .reload    (ctrl_q.reload),
  .wrap      (wrap),
  .ovf_flag  (stat_q[1]),
  .ovf_en    (ien_q[1]),
  .irq_o     (irq_o),
  .count_o   (count_o),
  .load      (load_q)
);

// File: tb/test_tick_timer.sv
module test_tick_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        irq_o;
  logic [31:0] count_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [2:0] A_CTRL = 3'd0, A_CNT = 3'd1, A_LOAD = 3'd2, A_STAT = 3'd3,
                         A_IEN = 3'd4, A_PINC = 3'd5, A_NINC = 3'd6;

  always #5 clk = ~clk;

  tick_timer i_tick_timer (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o), .count_o(count_o)
  );

  function automatic int div_of(bit pre_en, int sel);
    return pre_en ? (1 << (sel + 1)) : 1;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a falling edge; the write lands on the next rising edge
  task automatic wr(logic [2:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R11 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, base, ld;
    int k, n, dv, sel, wraps, ed, first, last, per_err, rl_err, nstr;
    bit pe, st, st_prev;
    logic [31:0] prev, cur;
    int signed acc;

    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check(count_o == 32'd0, "R1 count", count_o, 32'd0);
    check(irq_o == 1'b0, "R1 irq", {31'd0, irq_o}, 32'd0);
    rd(A_CTRL, v); check(v == 32'd0, "R1 ctrl", v, 32'd0);
    rd(A_STAT, v); check(v == 32'd0, "R1 status", v, 32'd0);
    rd(A_NINC, v); check(v == 32'd0, "R1 neg inc", v, 32'd0);

    // R12 direct writes
    wr(A_CNT, 32'h1234_5678);
    check(count_o == 32'h1234_5678, "R12 count write", count_o, 32'h1234_5678);
    wr(A_LOAD, 32'hCAFE_F00D);
    rd(A_LOAD, v); check(v == 32'hCAFE_F00D, "R12 load readback", v, 32'hCAFE_F00D);

    // R2 run and freeze, no prescale
    wr(A_CTRL, 32'd1);
    repeat (10) @(negedge clk);
    check(count_o == 32'h1234_5678 + 10, "R2 running", count_o, 32'h1234_5678 + 10);
    wr(A_CTRL, 32'd0);
    base = count_o;
    check(base == 32'h1234_5678 + 11, "R2 stop point", base, 32'h1234_5678 + 11);
    repeat (20) @(negedge clk);
    check(count_o == base, "R2 frozen", count_o, base);

    // R7, R5, R6, R8
    wr(A_IEN, 32'd2);
    wr(A_CNT, 32'hFFFF_FFFF);
    wr(A_CTRL, 32'd1);           // run, one-shot
    wr(A_STAT, 32'd2);           // clear lands on the wrap edge
    check(irq_o == 1'b1, "R7 overflow beats clear", {31'd0, irq_o}, 32'd1);
    check(count_o == 32'd0, "R5 count after one-shot wrap", count_o, 32'd0);
    rd(A_CTRL, v); check(v[0] == 1'b0, "R5 run cleared", v, 32'd0);
    wr(A_STAT, 32'd5);
    check(irq_o == 1'b1, "R6 zero bit keeps flag", {31'd0, irq_o}, 32'd1);
    wr(A_IEN, 32'd0);
    check(irq_o == 1'b0, "R8 masked", {31'd0, irq_o}, 32'd0);
    rd(A_STAT, v); check(v == 32'd2, "R6 status holds overflow", v, 32'd2);
    wr(A_IEN, 32'd2);
    check(irq_o == 1'b1, "R8 unmasked", {31'd0, irq_o}, 32'd1);
    wr(A_STAT, 32'd2);
    check(irq_o == 1'b0, "R6 cleared", {31'd0, irq_o}, 32'd0);
    rd(A_STAT, v); check(v == 32'd0, "R6 status empty", v, 32'd0);

    // R3, R4 random prescale and offset
    for (int it = 0; it < 20; it++) begin
      pe  = $urandom_range(1, 0);
      sel = $urandom_range(7, 0);
      n   = $urandom_range(6, 1);
      dv  = div_of(pe, sel);
      ld  = $urandom;
      wr(A_CTRL, 32'd0);
      wr(A_STAT, 32'd7);
      wr(A_CNT, 32'hFFFF_FFFF - (n - 1));
      wr(A_LOAD, ld);
      wr(A_CTRL, {25'd0, 1'($urandom_range(1, 0)), 3'(sel), pe, 1'b1, 1'b1});
      k = 0;
      while (k < 5000) begin
        @(negedge clk);
        k++;
        if (irq_o) break;
      end
      check(k == n * dv, "R3 clocks to overflow", k, n * dv);
      check(count_o == ld, "R4 reload value", count_o, ld);
    end

    // R10 plain periods with zero increments
    wr(A_CTRL, 32'd0);
    wr(A_LOAD, 32'hFFFF_FFF0);
    wr(A_CNT, 32'hFFFF_FFF0);
    wr(A_CTRL, 32'd3);
    prev = count_o; ed = 0; wraps = 0; last = 0; per_err = 0; rl_err = 0;
    while (wraps < 6) begin
      @(negedge clk); ed++; cur = count_o;
      if (cur < prev) begin
        wraps++;
        if (cur != 32'hFFFF_FFF0) rl_err++;
        if (wraps > 1 && ed - last != 16) per_err++;
        last = ed;
      end
      prev = cur;
    end
    check(per_err == 0, "R10 period length", per_err, 0);
    check(rl_err == 0, "R10 reload exact", rl_err, 0);

    // R9, R11 correction from a reset accumulator
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    wr(A_LOAD, 32'hFFFF_FFE0);
    wr(A_PINC, 32'd232000);
    wr(A_NINC, 32'hFFF4_4800);     // -768000
    wr(A_CNT, 32'hFFFF_FFE0);
    wr(A_CTRL, 32'd7);             // run, reload, prescale by 2
    prev = count_o; ed = 0; wraps = 0; first = 0; last = 0;
    per_err = 0; rl_err = 0; nstr = 0; acc = 0; st_prev = 1'b0;
    while (wraps < 1001) begin
      @(negedge clk); ed++; cur = count_o;
      if (cur < prev) begin
        wraps++;
        if (wraps == 1) first = ed;
        else if (ed - last != 2 * (32 + int'(st_prev))) per_err++;
        st = (acc < 0);
        if (cur != 32'hFFFF_FFE0 - {31'd0, st}) rl_err++;
        if (wraps <= 1000 && st) nstr++;
        acc = acc + (st ? 232000 : -768000);
        st_prev = st;
        last = ed;
      end
      prev = cur;
    end
    check(per_err == 0, "R9 per-period stretch", per_err, 0);
    check(rl_err == 0, "R9 reload minus one when negative", rl_err, 0);
    check(nstr == 768, "R11 stretched count", nstr, 768);
    check((last - first) == 2 * 32768, "R11 exact total", last - first, 2 * 32768);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule